// File: doc/BRIEF.md
# Gamepad State Register Bank

This block lets a processor read two game controllers through a small register window. Each controller arrives as a 32-bit button bitmap: bit = 1 means pressed. The bitmaps are produced in a different clock domain. Every bit is brought into the processor clock through its own two-flop synchroniser. Sixteen of the bits are then reordered into a fixed two-byte controller word, and each of those bits is inverted, so that a 0 means pressed.

The processor sees a 256-byte window, selected when address bits [31:8] equal the `WIN_BASE` parameter. Inside the window there are three live words: player one, player two and a status word. Writes anywhere are accepted and discarded. Read data is registered.

Top module: `pad_state_regs`

## Requirements
- R1: While reset is held, `bus_rdata` is 0. Right after reset, with both bitmaps at zero, a read of word index 0 or 1 returns 0x0000FFFF.
- R2: Word index 0 (byte offset 0x00) returns the player-one word. Its bits [7:0], from bit 7 down to bit 0, are the inverse of input bits 1, 2, 0, 3, 4, 15, 14, 5.
- R3: Bits [15:8] of a player word, from bit 15 down to bit 8, are the inverse of input bits 8, 7, 9, 6, 11, 10, 13, 12.
- R4: Word index 1 (byte offset 0x04) returns the player-two word. It has the same layout as the player-one word and depends only on `p2_buttons_async`.
- R5: Input bits 16 to 31 never affect a player word. Bits [31:16] of a player read are always 0. With no mapped button pressed, bits [15:0] read 0xFFFF.
- R6: Word index 2 (byte offset 0x08) reads 0x00000001.
- R7: Word indices 3 to 63 inside the window read 0. Address bits [1:0] are ignored, so any byte address inside a word reads that word.
- R8: A read whose address bits [31:8] differ from `WIN_BASE` returns 0.
- R9: Writes to any address have no effect. Later reads of all three live words return the same values they would have returned without the writes.
- R10: `bus_rdata` carries the read result in the cycle after `bus_rd` is high, and is 0 in the cycle after any cycle in which `bus_rd` is low.
- R11: Every input bit passes through a two-flop synchroniser. A change held steady at the inputs appears in reads that issue after three processor clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| bus_addr | input | 32 | Byte address |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe (writes are ignored) |
| bus_wdata | input | 32 | Write data (ignored) |
| bus_rdata | output | 32 | Registered read data |
| p1_buttons_async | input | 32 | Player-one bitmap from the foreign domain, active high |
| p2_buttons_async | input | 32 | Player-two bitmap from the foreign domain, active high |

## Verification
The hardest condition to reach from the ports is a bitmap change that lands close to a processor clock edge. A change like that makes the first synchroniser flop sample a moving value. The bench produces these changes from a separate 100 MHz clock whose period does not divide the processor period, so successive changes drift across the processor edge. After each change it reads only once the settling time of R11 has passed. Every single-bit pattern is swept on each player while the other player carries a mirrored pattern. This exposes any wrong index, any missing inversion and any cross-talk between the two players.

// File: rtl/pad_state_pkg.sv
package pad_state_pkg;

    localparam int PAD_W  = 16;
    localparam int DATA_W = 32;

    // Word indices inside the window (byte offset / 4); software relies on these.
    localparam int IDX_P1     = 0;
    localparam int IDX_P2     = 1;
    localparam int IDX_STATUS = 2;

    // Source bitmap bit that drives controller word bit k (before inversion).
    function automatic int pad_src_bit(input int k);
        case (k)
            0:       return 5;
            1:       return 14;
            2:       return 15;
            3:       return 4;
            4:       return 3;
            5:       return 0;
            6:       return 2;
            7:       return 1;
            8:       return 12;
            9:       return 13;
            10:      return 10;
            11:      return 11;
            12:      return 6;
            13:      return 9;
            14:      return 7;
            default: return 8;
        endcase
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

endpackage

// File: rtl/pad_sync2.sv
module pad_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stable;

endmodule

// File: rtl/pad_word_remap.sv
module pad_word_remap
    import pad_state_pkg::*;
#(
    parameter int IN_W = 32
) (
    input  logic [IN_W-1:0]  btn,
    output logic [PAD_W-1:0] pad_word
);

    localparam int EXTRA_W = IN_W - PAD_W;

    // Inputs above the mapped range are deliberately dropped.
    logic unused_extra;
    assign unused_extra = ^btn[IN_W-1:PAD_W];

    for (genvar k = 0; k < PAD_W; k++) begin : g_bit
        localparam int SRC = pad_src_bit(k);
        assign pad_word[k] = ~btn[SRC];
    end

    if (EXTRA_W < 1) begin : g_bad_width
        initial $display("pad_word_remap: IN_W must exceed PAD_W");
    end

endmodule

// File: rtl/pad_bus_decode.sv
module pad_bus_decode
    import pad_state_pkg::*;
#(
    parameter int                        ADDR_W   = 32,
    parameter int                        WIN_LSB  = 8,
    parameter logic [ADDR_W-WIN_LSB-1:0] WIN_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [PAD_W-1:0]  p1_word,
    input  logic [PAD_W-1:0]  p2_word,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int IDX_W = WIN_LSB - 2;

    bus_state_t st_d, st_q;

    logic             win_hit;
    logic [IDX_W-1:0] word_idx;

    // Writes and byte lanes carry no meaning here.
    logic unused_wr;
    assign unused_wr = bus_wr ^ (^bus_wdata) ^ (^bus_addr[1:0]);

    assign win_hit  = (bus_addr[ADDR_W-1:WIN_LSB] == WIN_BASE);
    assign word_idx = bus_addr[WIN_LSB-1:2];

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (bus_rd && win_hit) begin
            if (word_idx == IDX_W'(IDX_P1)) begin
                st_d.rdata = {{(DATA_W-PAD_W){1'b0}}, p1_word};
            end else if (word_idx == IDX_W'(IDX_P2)) begin
                st_d.rdata = {{(DATA_W-PAD_W){1'b0}}, p2_word};
            end else if (word_idx == IDX_W'(IDX_STATUS)) begin
                st_d.rdata = DATA_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/pad_state_regs.sv
module pad_state_regs
    import pad_state_pkg::*;
#(
    parameter int                        ADDR_W   = 32,
    parameter int                        WIN_LSB  = 8,
    parameter int                        BTN_W    = 32,
    parameter logic [ADDR_W-WIN_LSB-1:0] WIN_BASE = 24'h0040A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [BTN_W-1:0]  p1_buttons_async,
    input  logic [BTN_W-1:0]  p2_buttons_async
);

    localparam int N_PADS = 2;

    logic [N_PADS-1:0][BTN_W-1:0] raw_btn;
    logic [N_PADS-1:0][BTN_W-1:0] sync_btn;
    logic [N_PADS-1:0][PAD_W-1:0] pad_word;

    assign raw_btn[0] = p1_buttons_async;
    assign raw_btn[1] = p2_buttons_async;

    for (genvar p = 0; p < N_PADS; p++) begin : g_pad
        pad_sync2 #(
            .W (BTN_W)
        ) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_btn[p]),
            .sync_out (sync_btn[p])
        );

        pad_word_remap #(
            .IN_W (BTN_W)
        ) u_remap (
            .btn      (sync_btn[p]),
            .pad_word (pad_word[p])
        );
    end

    pad_bus_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_LSB  (WIN_LSB),
        .WIN_BASE (WIN_BASE)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .p1_word   (pad_word[0]),
        .p2_word   (pad_word[1]),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/pad_state_regs_chk.sv
module pad_state_regs_chk #(
    parameter int                        ADDR_W   = 32,
    parameter int                        WIN_LSB  = 8,
    parameter logic [ADDR_W-WIN_LSB-1:0] WIN_BASE = 24'h0040A5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [31:0]       bus_rdata
);

    localparam int IDX_W = WIN_LSB - 2;

    logic             hit;
    logic [IDX_W-1:0] idx;

    assign hit = (bus_addr[ADDR_W-1:WIN_LSB] == WIN_BASE);
    assign idx = bus_addr[WIN_LSB-1:2];

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (bus_rdata == 32'd0); // R1
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 32'd0); // R10

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd) |=> bus_rdata == 32'd0); // R9

    AST_STATUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && idx == IDX_W'(2)) |=> bus_rdata == 32'd1); // R6

    AST_PAD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && idx < IDX_W'(2)) |=> bus_rdata[31:16] == 16'd0); // R5

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && idx > IDX_W'(2)) |=> bus_rdata == 32'd0); // R7

    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |=> bus_rdata == 32'd0); // R8

endmodule

bind pad_state_regs pad_state_regs_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_LSB  (WIN_LSB),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata)
);

// File: tb/tb_pad_state_regs.sv
`timescale 1ns/1ps
module tb_pad_state_regs;

    localparam logic [23:0] BASE = 24'h0040A5;
    localparam logic [31:0] A0   = {BASE, 8'h00};

    logic        clk = 1'b0;
    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] p1_src = '0;
    logic [31:0] p2_src = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Controller word bit k <- inverse of bitmap bit map_tab[k] (R2, R3).
    int map_tab [16] = '{5, 14, 15, 4, 3, 0, 2, 1, 12, 13, 10, 11, 6, 9, 7, 8};

    always #4 clk  = ~clk;
    always #5 sclk = ~sclk;

    pad_state_regs dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_addr         (bus_addr),
        .bus_rd           (bus_rd),
        .bus_wr           (bus_wr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .p1_buttons_async (p1_src),
        .p2_buttons_async (p2_src)
    );

    function automatic logic [31:0] exp_word(input logic [31:0] b);
        logic [15:0] w = 16'hFFFF;
        for (int k = 0; k < 16; k++) begin
            if (b[map_tab[k]]) w[k] = 1'b0;
        end
        return {16'h0000, w};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
        end
    endtask

    task automatic set_inputs(input logic [31:0] a, input logic [31:0] b, input int settle);
        @(posedge sclk);
        #1;
        p1_src = a;
        p2_src = b;
        repeat (settle) @(posedge clk);
    endtask

    task automatic do_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        d      = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] lfsr;

        // R1: quiet during reset, idle word after reset
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        do_read(A0, d);
        check("R1 p1 after reset", d, 32'h0000FFFF);
        do_read(A0 + 4, d);
        check("R1 p2 after reset", d, 32'h0000FFFF);

        // R10: rdata returns to 0 after a read cycle
        @(negedge clk);
        check("R10 idle after read", bus_rdata, 32'h0);

        // R6
        do_read(A0 + 8, d);
        check("R6 status", d, 32'h1);

        // R2 R3 R4 R5: walk every bitmap bit on both players
        for (int i = 0; i < 32; i++) begin
            a = 32'h1 << i;
            b = 32'h1 << (31 - i);
            set_inputs(a, b, 6);
            do_read(A0, d);
            check($sformatf("R2 R3 R5 p1 bit %0d", i), d, exp_word(a));
            do_read(A0 + 4, d);
            check($sformatf("R4 p2 bit %0d", 31 - i), d, exp_word(b));
        end

        // R5: only unmapped bits set -> no press
        set_inputs(32'hFFFF_0000, 32'h0001_0000, 6);
        do_read(A0, d);
        check("R5 high bits p1", d, 32'h0000FFFF);
        do_read(A0 + 4, d);
        check("R5 menu bit p2", d, 32'h0000FFFF);

        // R2 R3: combinations
        set_inputs(32'h0000_0071, 32'h0000_FFFF, 6);
        do_read(A0, d);
        check("R2 R3 combo", d, 32'h0000EFD6);
        do_read(A0 + 4, d);
        check("R3 all pressed", d, 32'h0000_0000);

        // R4: pseudo-random independent patterns
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            b = lfsr ^ 32'h5A5A_C3C3;
            set_inputs(a, b, 6);
            do_read(A0, d);
            check("R2 R3 random p1", d, exp_word(a));
            do_read(A0 + 4, d);
            check("R4 random p2", d, exp_word(b));
        end

        // R11: change held steady, read after three processor edges
        set_inputs(32'h0000_0000, 32'h0000_0000, 6);
        set_inputs(32'h0000_0400, 32'h0000_0001, 3);
        do_read(A0, d);
        check("R11 p1 settled", d, exp_word(32'h0000_0400));
        do_read(A0 + 4, d);
        check("R11 p2 settled", d, exp_word(32'h0000_0001));

        // R9: writes everywhere change nothing
        set_inputs(32'h0000_2209, 32'h0000_8050, 6);
        for (int i = 0; i < 64; i++) do_write(A0 + 32'(i * 4), 32'hFFFF_FFFF);
        do_write(A0 + 1, 32'h0);
        do_read(A0, d);
        check("R9 p1 after writes", d, exp_word(32'h0000_2209));
        do_read(A0 + 4, d);
        check("R9 p2 after writes", d, exp_word(32'h0000_8050));
        do_read(A0 + 8, d);
        check("R9 status after writes", d, 32'h1);

        // R7: reserved words and ignored byte lanes
        for (int i = 3; i < 64; i++) begin
            do_read(A0 + 32'(i * 4), d);
            check($sformatf("R7 reserved idx %0d", i), d, 32'h0);
        end
        for (int i = 1; i < 4; i++) begin
            do_read(A0 + 32'(i), d);
            check("R7 byte lane p1", d, exp_word(32'h0000_2209));
            do_read(A0 + 8 + 32'(i), d);
            check("R7 byte lane status", d, 32'h1);
        end

        // R8: outside the window
        for (int i = 8; i < 32; i++) begin
            do_read(A0 ^ (32'h1 << i), d);
            check($sformatf("R8 outside flip %0d", i), d, 32'h0);
        end

        // R10: last read followed by an idle cycle
        do_read(A0 + 4, d);
        @(negedge clk);
        check("R10 idle after p2 read", bus_rdata, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule